// File: doc/BRIEF.md
# Packetised Block-Write Sender

This block streams a block-write payload onto a byte-wide serial link once the command phase has been accepted. The payload arrives on a valid/ready byte stream and the block cuts it into packets of a programmable power-of-two size. Each packet starts with a marker byte that says whether it opens, continues or closes the transfer. When checksums are enabled, a 16-bit CRC trailer follows the packet. Nothing is read back between packets.

After the closing packet, the block clocks four dummy bytes through the link and keeps what comes back. It searches that window backwards for the response that belongs to the final packet, because replies to earlier packets may still be in the window ahead of it. It then reports success, a missing response or a bad response. Transfers of four bytes or fewer are refused at once and put nothing on the link.

Top module: `pkt_wr_sender`

## Requirements
- R1: A start with `xfer_len` of 4 or less puts no byte on the link and takes no payload. The block raises `done` in the following cycle with `status` = 1 (too short).
- R2: The packet size is 2^(8+c) bytes, where c is `pkt_size_code` sampled at start. Codes 6 and 7 are treated as 5, which gives 8192 bytes.
- R3: Each packet opens with the byte 0xF0 | order. The order is 3 for the packet that ends the transfer, including a transfer that fits in one packet. It is 1 for the first of several packets and 2 for every packet in between.
- R4: Every packet except the last carries a full packet of payload. The last packet carries only the bytes that remain.
- R5: When `crc_en` is 1 at start, two trailer bytes follow each packet's payload, high byte first. They hold a CRC16 over that packet's payload only: polynomial 0x1021, initial value 0xFFFF, message bits taken MSB first. When `crc_en` is 0, no trailer is sent.
- R6: After the last packet, exactly four exchanges follow, each sending 0x00 and capturing `sh_in`. No exchange happens between packets other than header, payload and trailer bytes, and no exchange happens while the block is idle.
- R7: The four captured bytes w0..w3 (in exchange order) are searched at indices 2, 1, 0 in that order, and the first byte whose upper nibble is 0xC is chosen. `status` is 0 if that byte's lower nibble is 3 and the next byte is 0x00, otherwise 3. If no index matches, `status` is 2. Index 3 is never a candidate.
- R8: While `sh_req` is high and `sh_ack` low, `sh_out` and `sh_req` hold their values into the next cycle. Each `sh_ack` pulse completes exactly one byte exchange.
- R9: Payload bytes are taken only on `pl_valid && pl_ready` and go out in arrival order. `pl_ready` is never high while a byte exchange is pending.
- R10: `start` is ignored while `busy` is high. `done` is a one-cycle pulse that coincides with `busy` falling. `status` holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (one cycle) |
| xfer_len | input | LEN_W | Payload length in bytes |
| pkt_size_code | input | 3 | Packet size code, sampled at start |
| crc_en | input | 1 | Enable per-packet CRC16 trailer, sampled at start |
| pl_valid | input | 1 | Payload byte valid |
| pl_data | input | 8 | Payload byte |
| pl_ready | output | 1 | Payload byte accepted |
| sh_req | output | 1 | Byte exchange requested |
| sh_out | output | 8 | Byte to shift out |
| sh_ack | input | 1 | Exchange complete (one cycle) |
| sh_in | input | 8 | Byte shifted in during the acknowledged exchange |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished (one cycle) |
| status | output | 2 | 0 ok, 1 too short, 2 no response, 3 bad response |

## Verification
Two events share one cycle whenever the link acknowledges the last payload byte of a packet. In that cycle the CRC must fold that byte in and the trailer high byte must be chosen from the updated value. Without a trailer, the next header or the response phase must be picked from the remaining count as it stands after that byte. The bench provokes this by acknowledging some exchanges in the same cycle the request is seen and others a cycle later. Packet sizes are chosen so that packet ends fall on both kinds of acknowledgement. The scoreboard then judges every header, trailer and dummy byte against a model built from the requirements. A second collision is a start pulse arriving mid-transfer; it must leave the byte sequence and the final status untouched.

// File: rtl/pkt_wr_pkg.sv
package pkt_wr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_DATA,
        PH_CRC_HI,
        PH_CRC_LO,
        PH_RESP,
        PH_FIN
    } phase_e;

    typedef enum logic [1:0] {
        XS_OK     = 2'd0,
        XS_SHORT  = 2'd1,
        XS_NOTAG  = 2'd2,
        XS_BADRSP = 2'd3
    } xfer_status_e;

    localparam logic [3:0]  HDR_NIBBLE   = 4'hF;
    localparam logic [3:0]  RSP_TAG      = 4'hC;
    localparam logic [3:0]  RSP_LAST     = 4'h3;
    localparam logic [1:0]  ORD_FIRST    = 2'd1;
    localparam logic [1:0]  ORD_INNER    = 2'd2;
    localparam logic [1:0]  ORD_LAST     = 2'd3;
    localparam logic [15:0] CRC_SEED     = 16'hFFFF;
    localparam logic [15:0] CRC_POLY     = 16'h1021;
    localparam int          MIN_LEN      = 4;
    localparam int          WIN_BYTES    = 4;

endpackage

// File: rtl/pkt_wr_crc16.sv
module pkt_wr_crc16 (
    input  logic [15:0] crc_in,
    input  logic [7:0]  din,
    output logic [15:0] crc_out
);
    import pkt_wr_pkg::*;

    always_comb begin
        logic [15:0] c;
        c = crc_in;
        for (int b = 7; b >= 0; b--) begin
            if (c[15] ^ din[b]) c = {c[14:0], 1'b0} ^ CRC_POLY;
            else                c = {c[14:0], 1'b0};
        end
        crc_out = c;
    end

endmodule

// File: rtl/pkt_wr_plan.sv
module pkt_wr_plan #(
    parameter int LEN_W    = 16,
    parameter int LOG_BASE = 8,
    parameter int CODE_MAX = 5
) (
    input  logic [LEN_W-1:0] remain,
    input  logic [2:0]       size_code,
    input  logic             first,
    output logic [LEN_W-1:0] pkt_bytes,
    output logic [1:0]       order
);
    import pkt_wr_pkg::*;

    localparam logic [2:0] CODE_CAP = 3'(CODE_MAX);

    logic [2:0]     eff_code;
    logic [LEN_W:0] pkt_size;

    always_comb begin
        eff_code = (size_code > CODE_CAP) ? CODE_CAP : size_code;
        pkt_size = (LEN_W+1)'(1) << (LOG_BASE + 32'(eff_code));
        if ({1'b0, remain} <= pkt_size) begin
            pkt_bytes = remain;
            order     = ORD_LAST;
        end else begin
            pkt_bytes = pkt_size[LEN_W-1:0];
            order     = first ? ORD_FIRST : ORD_INNER;
        end
    end

endmodule

// File: rtl/pkt_wr_scan.sv
module pkt_wr_scan (
    input  logic [3:0][7:0] win,
    output logic            found,
    output logic            ok
);
    import pkt_wr_pkg::*;

    always_comb begin
        found = 1'b0;
        ok    = 1'b0;
        for (int i = WIN_BYTES - 2; i >= 0; i--) begin
            if (!found && win[i][7:4] == RSP_TAG) begin
                found = 1'b1;
                ok    = (win[i][3:0] == RSP_LAST) && (win[i+1] == 8'h00);
            end
        end
    end

endmodule

// File: rtl/pkt_wr_sender.sv
module pkt_wr_sender #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic [2:0]       pkt_size_code,
    input  logic             crc_en,
    input  logic             pl_valid,
    input  logic [7:0]       pl_data,
    output logic             pl_ready,
    output logic             sh_req,
    output logic [7:0]       sh_out,
    input  logic             sh_ack,
    input  logic [7:0]       sh_in,
    output logic             busy,
    output logic             done,
    output logic [1:0]       status
);
    import pkt_wr_pkg::*;

    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_LEN);

    typedef struct packed {
        phase_e          ph;
        logic            req;
        logic [7:0]      obyte;
        logic [LEN_W-1:0] remain;
        logic [LEN_W-1:0] pkt_left;
        logic [2:0]      code;
        logic            crc_on;
        logic [15:0]     crc;
        logic [3:0][7:0] win;
        logic [1:0]      widx;
        logic            done;
        xfer_status_e    status;
    } state_t;

    state_t q, d;

    // Packet planner: at start it sees the requested length, later the bytes still owed.
    logic [LEN_W-1:0] plan_remain;
    logic [2:0]       plan_code;
    logic             plan_first;
    logic [LEN_W-1:0] plan_bytes;
    logic [1:0]       plan_order;

    always_comb begin
        plan_first = (q.ph == PH_IDLE);
        plan_code  = plan_first ? pkt_size_code : q.code;
        if (plan_first)             plan_remain = xfer_len;
        else if (q.ph == PH_DATA)   plan_remain = q.remain - LEN_ONE;
        else                        plan_remain = q.remain;
    end

    pkt_wr_plan #(.LEN_W(LEN_W)) u_plan (
        .remain    (plan_remain),
        .size_code (plan_code),
        .first     (plan_first),
        .pkt_bytes (plan_bytes),
        .order     (plan_order)
    );

    logic [15:0] crc_upd;

    pkt_wr_crc16 u_crc (
        .crc_in  (q.crc),
        .din     (q.obyte),
        .crc_out (crc_upd)
    );

    logic scan_found, scan_ok;

    pkt_wr_scan u_scan (
        .win   (q.win),
        .found (scan_found),
        .ok    (scan_ok)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        pl_ready = 1'b0;

        unique case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    if (xfer_len <= LEN_MIN) begin
                        d.done   = 1'b1;
                        d.status = XS_SHORT;
                    end else begin
                        d.remain   = xfer_len;
                        d.code     = pkt_size_code;
                        d.crc_on   = crc_en;
                        d.ph       = PH_HDR;
                        d.obyte    = {HDR_NIBBLE, 2'b00, plan_order};
                        d.req      = 1'b1;
                        d.pkt_left = plan_bytes;
                        d.crc      = CRC_SEED;
                    end
                end
            end

            PH_HDR: begin
                if (sh_ack) begin
                    d.req = 1'b0;
                    d.ph  = PH_DATA;
                end
            end

            PH_DATA: begin
                if (!q.req) begin
                    pl_ready = 1'b1;
                    if (pl_valid) begin
                        d.obyte = pl_data;
                        d.req   = 1'b1;
                    end
                end else if (sh_ack) begin
                    d.req      = 1'b0;
                    d.crc      = crc_upd;
                    d.remain   = q.remain - LEN_ONE;
                    d.pkt_left = q.pkt_left - LEN_ONE;
                    if (q.pkt_left == LEN_ONE) begin
                        if (q.crc_on) begin
                            d.ph    = PH_CRC_HI;
                            d.obyte = crc_upd[15:8];
                            d.req   = 1'b1;
                        end else if (q.remain == LEN_ONE) begin
                            d.ph    = PH_RESP;
                            d.obyte = 8'h00;
                            d.req   = 1'b1;
                            d.widx  = 2'd0;
                        end else begin
                            d.ph       = PH_HDR;
                            d.obyte    = {HDR_NIBBLE, 2'b00, plan_order};
                            d.req      = 1'b1;
                            d.pkt_left = plan_bytes;
                            d.crc      = CRC_SEED;
                        end
                    end
                end
            end

            PH_CRC_HI: begin
                if (sh_ack) begin
                    d.obyte = q.crc[7:0];
                    d.ph    = PH_CRC_LO;
                end
            end

            PH_CRC_LO: begin
                if (sh_ack) begin
                    if (q.remain == '0) begin
                        d.ph    = PH_RESP;
                        d.obyte = 8'h00;
                        d.req   = 1'b1;
                        d.widx  = 2'd0;
                    end else begin
                        d.ph       = PH_HDR;
                        d.obyte    = {HDR_NIBBLE, 2'b00, plan_order};
                        d.req      = 1'b1;
                        d.pkt_left = plan_bytes;
                        d.crc      = CRC_SEED;
                    end
                end
            end

            PH_RESP: begin
                if (sh_ack) begin
                    d.win[q.widx] = sh_in;
                    if (q.widx == 2'd3) begin
                        d.req = 1'b0;
                        d.ph  = PH_FIN;
                    end else begin
                        d.widx = q.widx + 2'd1;
                    end
                end
            end

            PH_FIN: begin
                d.done = 1'b1;
                d.ph   = PH_IDLE;
                if (!scan_found)   d.status = XS_NOTAG;
                else if (scan_ok)  d.status = XS_OK;
                else               d.status = XS_BADRSP;
            end

            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ph       <= PH_IDLE;
            q.req      <= 1'b0;
            q.obyte    <= 8'h00;
            q.remain   <= '0;
            q.pkt_left <= '0;
            q.code     <= 3'd0;
            q.crc_on   <= 1'b0;
            q.crc      <= CRC_SEED;
            q.win      <= '0;
            q.widx     <= 2'd0;
            q.done     <= 1'b0;
            q.status   <= XS_OK;
        end else begin
            q <= d;
        end
    end

    assign sh_req = q.req;
    assign sh_out = q.obyte;
    assign busy   = (q.ph != PH_IDLE);
    assign done   = q.done;
    assign status = q.status;

endmodule

// File: rtl/pkt_wr_sender_chk.sv
module pkt_wr_sender_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] xfer_len,
    input logic             pl_ready,
    input logic             sh_req,
    input logic [7:0]       sh_out,
    input logic             sh_ack,
    input logic             busy,
    input logic             done,
    input logic [1:0]       status
);

    assert_short_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && xfer_len <= LEN_W'(4)) |=> (done && status == 2'd1));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sh_req);

    assert_hold_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_req && !sh_ack) |=> (sh_req && $stable(sh_out)));

    assert_no_fetch_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pl_ready |-> !sh_req);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_with_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

bind pkt_wr_sender pkt_wr_sender_chk #(.LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .xfer_len (xfer_len),
    .pl_ready (pl_ready),
    .sh_req   (sh_req),
    .sh_out   (sh_out),
    .sh_ack   (sh_ack),
    .busy     (busy),
    .done     (done),
    .status   (status)
);

// File: tb/tb_pkt_wr_sender.sv
`timescale 1ns/1ps
module tb_pkt_wr_sender;
    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic [2:0]       pkt_size_code = 3'd0;
    logic             crc_en = 1'b0;
    logic             pl_valid = 1'b0;
    logic [7:0]       pl_data = 8'h00;
    logic             pl_ready;
    logic             sh_req;
    logic [7:0]       sh_out;
    logic             sh_ack = 1'b0;
    logic [7:0]       sh_in = 8'h00;
    logic             busy, done;
    logic [1:0]       status;

    always #4 clk = ~clk;

    pkt_wr_sender #(.LEN_W(LEN_W)) dut (.*);

    int n_vec = 0;
    int n_bad = 0;
    byte unsigned exp_q[$];
    byte unsigned pl_q[$];
    byte unsigned rsp_win[4];
    int  seen = 0;
    int  resp_base = 0;
    string cur_tag = "R3";

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        n_vec++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input byte unsigned v);
        logic [15:0] r;
        r = c;
        for (int b = 7; b >= 0; b--)
            r = (r[15] ^ v[b]) ? ({r[14:0], 1'b0} ^ 16'h1021) : {r[14:0], 1'b0};
        return r;
    endfunction

    // Link model and monitor: pops expected bytes and supplies the response window.
    initial begin
        forever begin
            @(negedge clk);
            sh_ack = 1'b0;
            if (sh_req) begin
                if ((seen % 3) == 1) @(negedge clk);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected exchange", sh_out, 0);
                end else begin
                    byte unsigned e;
                    e = exp_q.pop_front();
                    chk(sh_out == e, cur_tag, sh_out, e);
                end
                sh_in  = (seen >= resp_base && seen < resp_base + 4) ? rsp_win[seen - resp_base] : 8'hA5;
                seen++;
                sh_ack = 1'b1;
            end
        end
    end

    // Payload source with periodic stalls.
    initial begin
        bit fire;
        int tick;
        fire = 1'b0;
        tick = 0;
        forever begin
            @(negedge clk);
            if (fire) void'(pl_q.pop_front());
            if (pl_q.size() > 0 && (tick % 5) != 3) begin
                pl_valid = 1'b1;
                pl_data  = pl_q[0];
            end else begin
                pl_valid = 1'b0;
            end
            fire = pl_valid && pl_ready;
            tick++;
        end
    end

    task automatic run_xfer(input int len, input int code, input bit crc,
                            input byte unsigned w0, input byte unsigned w1,
                            input byte unsigned w2, input byte unsigned w3,
                            input int exp_st, input bit poke, input string tag);
        int eff, psz, rem, n, idx;
        bit first;
        logic [15:0] c;
        logic [1:0] st_at_done;
        cur_tag = tag;
        seen = 0;
        rsp_win[0] = w0; rsp_win[1] = w1; rsp_win[2] = w2; rsp_win[3] = w3;
        if (len > 4) begin
            eff = (code > 5) ? 5 : code;
            psz = 1 << (8 + eff);
            rem = len; first = 1'b1; idx = 0;
            while (rem > 0) begin
                n = (rem <= psz) ? rem : psz;
                exp_q.push_back(8'hF0 | ((rem <= psz) ? 3 : (first ? 1 : 2)));
                c = 16'hFFFF;
                for (int i = 0; i < n; i++) begin
                    byte unsigned b;
                    b = byte'((idx * 7 + len + 13) & 8'hFF);
                    pl_q.push_back(b);
                    exp_q.push_back(b);
                    c = crc_step(c, b);
                    idx++;
                end
                if (crc) begin
                    exp_q.push_back(c[15:8]);
                    exp_q.push_back(c[7:0]);
                end
                rem -= n; first = 1'b0;
            end
            resp_base = exp_q.size();
            for (int i = 0; i < 4; i++) exp_q.push_back(8'h00);
        end else begin
            resp_base = 0;
        end
        @(negedge clk);
        start = 1'b1; xfer_len = LEN_W'(len); pkt_size_code = 3'(code); crc_en = crc;
        @(negedge clk);
        start = 1'b0;
        begin
            int cyc;
            cyc = 0;
            while (!done) begin
                @(negedge clk);
                cyc++;
                if (poke && cyc == 40) begin
                    start = 1'b1; xfer_len = LEN_W'(3);
                end else begin
                    start = 1'b0;
                end
            end
            start = 1'b0;
        end
        st_at_done = status;
        chk(st_at_done == 2'(exp_st), {tag, " R7 status"}, st_at_done, exp_st);
        chk(exp_q.size() == 0, {tag, " R4 all bytes sent"}, exp_q.size(), 0);
        chk(pl_q.size() == 0, {tag, " R9 payload consumed"}, pl_q.size(), 0);
        @(negedge clk);
        chk(!done && !busy, "R10 done one pulse", done, 0);
        repeat (3) @(negedge clk);
        chk(status == st_at_done, "R10 status held", status, st_at_done);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !sh_req && !pl_ready, "R6 reset state",
            {busy, done, sh_req, pl_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: too short, nothing exchanged
        run_xfer(4, 0, 1'b1, 0, 0, 0, 0, 1, 1'b0, "R1");
        chk(seen == 0, "R1 no exchange", seen, 0);
        run_xfer(0, 0, 1'b0, 0, 0, 0, 0, 1, 1'b0, "R1");
        chk(seen == 0, "R1 no exchange len0", seen, 0);

        // R3 single short packet, no trailer, tag at index 0
        run_xfer(5, 0, 1'b0, 8'hC3, 8'h00, 8'hFF, 8'hFF, 0, 1'b0, "R3 R6");
        // R5 exact one packet with trailer, tag at index 2
        run_xfer(256, 0, 1'b1, 8'h00, 8'h00, 8'hC3, 8'h00, 0, 1'b0, "R5");
        // R3/R4/R5 three packets; index 2 wins over index 0 (R7); start poke ignored (R10)
        run_xfer(600, 0, 1'b1, 8'hC3, 8'h00, 8'hC1, 8'h00, 3, 1'b1, "R3 R4 R5 R10");
        // R2 code 1, no trailer
        run_xfer(1100, 1, 1'b0, 8'h00, 8'hC3, 8'h00, 8'h55, 0, 1'b0, "R2 R4");
        // R2 code 7 clamps; tag only at index 3 -> no response (R7)
        run_xfer(300, 7, 1'b1, 8'h00, 8'h00, 8'h00, 8'hC3, 2, 1'b0, "R2 R7");
        // R7 bad status byte
        run_xfer(20, 2, 1'b0, 8'hC3, 8'h07, 8'h00, 8'h00, 3, 1'b0, "R7");
        // R2 code 6 clamps to 8192
        run_xfer(9, 6, 1'b0, 8'h11, 8'hC3, 8'h00, 8'h00, 0, 1'b0, "R2");
        // R2/R4 largest packet plus one trailing byte
        run_xfer(8193, 5, 1'b1, 8'h11, 8'hC3, 8'h00, 8'h00, 0, 1'b0, "R2 R4 R5");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R10 actual=0x%0h expected=0x%0h", busy, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule